// File: doc/BRIEF.md
# Prioritised DMA Channel Grant Arbiter

This block decides which of several DMA channels may use a single shared bus master port. Each channel collects a small group of peripheral request lines. A channel competes only when it is switched on, still has transfers left, and at least one of its request lines is high. Software gives each channel a two-bit urgency level. The highest level wins, and among channels on the same level the lowest channel index wins.

The winner receives a registered one-hot grant together with a grant-valid flag. The grant stays fixed until the channel datapath reports that the current read-then-write beat is complete. In the cycle that the beat completes, the peripheral request lines of the granted channel receive an acknowledge. In the same cycle the arbiter chooses the next owner from the requests present at that moment.

Top module: `dma_prio_arbiter`

## Requirements
- R1: While `rst_n` is low, `gnt` is all zeros and `gnt_vld` is 0, whatever the request inputs are.
- R2: Channel c is eligible only when `ch_en[c]` is 1, `ch_cnt_nz[c]` is 1, and at least one of its request lines `per_req[c*NPER +: NPER]` is 1. A channel that is not eligible is never granted.
- R3: The urgency of channel c is `ch_prio[2c+1:2c]`: 2'b11 is very high, 2'b10 is high, 2'b01 is medium and 2'b00 is low. The eligible channel with the highest urgency wins.
- R4: When two or more eligible channels share the highest urgency, the one with the lowest index wins.
- R5: Arbitration happens on each rising clock edge where `gnt_vld` is 0 or `beat_done` is 1. The result is visible on `gnt` and `gnt_vld` from that edge onward, one cycle after the inputs were presented.
- R6: While `gnt_vld` is 1 and `beat_done` is 0, `gnt` does not change. This holds even when a more urgent channel requests or the owner's inputs drop.
- R7: When `beat_done` is 1 and no channel is eligible, `gnt_vld` falls at the next edge. When `beat_done` is 1 and some channel is eligible, the next owner is that channel, and it may be the same channel as before.
- R8: `gnt` has at most one bit set, and `gnt_vld` is 1 exactly when a bit of `gnt` is set.
- R9: `per_ack[i]` is 1 only when `beat_done` is 1, request line i is high, and line i belongs to the channel that currently holds the grant. Otherwise `per_ack[i]` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| per_req | input | NCH*NPER | Peripheral request lines, NPER per channel |
| ch_en | input | NCH | Channel switched on |
| ch_cnt_nz | input | NCH | Channel has transfers remaining |
| ch_prio | input | 2*NCH | Two-bit urgency per channel |
| beat_done | input | 1 | Current owner finished its beat |
| gnt | output | NCH | One-hot registered grant |
| gnt_vld | output | 1 | A grant is held |
| per_ack | output | NCH*NPER | Acknowledge to peripheral request lines |

## Verification
Two things can happen in the same cycle: a beat finishes, with its acknowledge and the release of the grant, and a new owner is chosen from requests that have only just appeared. The bench provokes this by raising `beat_done` while, in that same cycle, it changes the request lines, the urgency levels and the enable bits, including a case where a more urgent channel appears right at completion. A bench model computes both the acknowledge expected in that cycle and the owner expected one edge later, and the design is compared against both.

// File: rtl/dma_prio_arbiter.sv
module dma_prio_arbiter #(
  parameter int NCH  = 5,
  parameter int NPER = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NCH*NPER-1:0]  per_req,
  input  logic [NCH-1:0]       ch_en,
  input  logic [NCH-1:0]       ch_cnt_nz,
  input  logic [2*NCH-1:0]     ch_prio,
  input  logic                 beat_done,
  output logic [NCH-1:0]       gnt,
  output logic                 gnt_vld,
  output logic [NCH*NPER-1:0]  per_ack
);

  logic [NCH-1:0] ch_req, elig, win;
  logic [1:0]     best;
  logic           found;
  logic           rearb;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign ch_req[c] = |per_req[c*NPER +: NPER];
    assign per_ack[c*NPER +: NPER] = per_req[c*NPER +: NPER] & {NPER{gnt[c] & beat_done}};
  end

  assign elig = ch_req & ch_en & ch_cnt_nz;

  always_comb begin
    win   = '0;
    best  = 2'b00;
    found = 1'b0;
    for (int c = 0; c < NCH; c++) begin
      if (elig[c] && (!found || ch_prio[2*c +: 2] > best)) begin
        win    = '0;
        win[c] = 1'b1;
        best   = ch_prio[2*c +: 2];
        found  = 1'b1;
      end
    end
  end

  assign rearb = !gnt_vld || beat_done;

  always_ff @(posedge clk) begin
    if (!rst_n)     gnt <= '0;
    else if (rearb) gnt <= win;
  end

  assign gnt_vld = |gnt;

endmodule

module dma_prio_arbiter_chk #(
  parameter int NCH  = 5,
  parameter int NPER = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NCH*NPER-1:0] per_req,
  input logic [NCH-1:0]      ch_en,
  input logic [NCH-1:0]      ch_cnt_nz,
  input logic                beat_done,
  input logic [NCH-1:0]      gnt,
  input logic                gnt_vld,
  input logic [NCH*NPER-1:0] per_ack
);
  logic [NCH-1:0] ok_ch;
  for (genvar c = 0; c < NCH; c++) begin : g_ok
    assign ok_ch[c] = (|per_req[c*NPER +: NPER]) & ch_en[c] & ch_cnt_nz[c];
  end

  AST_GNT_ONEHOT:  assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gnt) && (gnt_vld == (gnt != '0))); // R8
  AST_GNT_HOLD:    assert property (@(posedge clk) disable iff (!rst_n) (gnt_vld && !beat_done) |=> $stable(gnt)); // R6
  AST_ACK_IDLE:    assert property (@(posedge clk) disable iff (!rst_n) !beat_done |-> (per_ack == '0)); // R9
  AST_ACK_SUBSET:  assert property (@(posedge clk) disable iff (!rst_n) (per_ack & ~per_req) == '0); // R9
  AST_IDLE_PICKUP: assert property (@(posedge clk) disable iff (!rst_n) (!gnt_vld && ok_ch != '0) |=> gnt_vld); // R5
  AST_DONE_EMPTY:  assert property (@(posedge clk) disable iff (!rst_n) (beat_done && ok_ch == '0) |=> !gnt_vld); // R7
  AST_GNT_ELIG:    assert property (@(posedge clk) disable iff (!rst_n) ((!gnt_vld || beat_done) && ok_ch != '0) |=> ((gnt & $past(ok_ch)) != '0)); // R2
endmodule

bind dma_prio_arbiter dma_prio_arbiter_chk #(.NCH(NCH), .NPER(NPER)) u_chk (
  .clk(clk), .rst_n(rst_n), .per_req(per_req), .ch_en(ch_en), .ch_cnt_nz(ch_cnt_nz),
  .beat_done(beat_done), .gnt(gnt), .gnt_vld(gnt_vld), .per_ack(per_ack)
);

// File: tb/dma_prio_arbiter_bench.sv
module dma_prio_arbiter_bench;
  localparam int NCH  = 5;
  localparam int NPER = 3;
  localparam int NL   = NCH*NPER;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NL-1:0] per_req;
  logic [NCH-1:0] ch_en, ch_cnt_nz;
  logic [2*NCH-1:0] ch_prio;
  logic          beat_done;
  logic [NCH-1:0] gnt;
  logic          gnt_vld;
  logic [NL-1:0] per_ack;

  int n_vec = 0;
  int n_bad = 0;
  logic [NCH-1:0] m_gnt;

  always #2.5 clk = ~clk;

  dma_prio_arbiter #(.NCH(NCH), .NPER(NPER)) u_dma_prio_arbiter (
    .clk(clk), .rst_n(rst_n), .per_req(per_req), .ch_en(ch_en), .ch_cnt_nz(ch_cnt_nz),
    .ch_prio(ch_prio), .beat_done(beat_done), .gnt(gnt), .gnt_vld(gnt_vld), .per_ack(per_ack)
  );

  function automatic logic [NCH-1:0] exp_pick(input logic [NL-1:0] rq, input logic [NCH-1:0] en,
                                               input logic [NCH-1:0] nz, input logic [2*NCH-1:0] pr);
    logic [NCH-1:0] r = '0;
    for (int lvl = 0; lvl < 4; lvl++)
      for (int c = NCH-1; c >= 0; c--)
        if (en[c] && nz[c] && (rq[c*NPER +: NPER] != '0) && pr[2*c +: 2] == 2'(lvl)) begin
          r = '0; r[c] = 1'b1;
        end
    return r;
  endfunction

  function automatic logic [NL-1:0] exp_ack(input logic [NCH-1:0] g, input logic [NL-1:0] rq, input logic d);
    logic [NL-1:0] a = '0;
    for (int c = 0; c < NCH; c++)
      if (g[c] && d) a[c*NPER +: NPER] = rq[c*NPER +: NPER];
    return a;
  endfunction

  task automatic chk(input string tag, input logic [NL-1:0] act, input logic [NL-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input string tag, input logic [NL-1:0] rq, input logic [NCH-1:0] en,
                      input logic [NCH-1:0] nz, input logic [2*NCH-1:0] pr, input logic d);
    logic [NCH-1:0] nxt;
    per_req = rq; ch_en = en; ch_cnt_nz = nz; ch_prio = pr; beat_done = d;
    #1;
    chk("R9 ack", NL'(per_ack), exp_ack(m_gnt, rq, d));
    nxt = (m_gnt == '0 || d) ? exp_pick(rq, en, nz, pr) : m_gnt;
    m_gnt = nxt;
    @(negedge clk);
    chk(tag, NL'(gnt), NL'(m_gnt));
    chk("R8 vld", NL'(gnt_vld), NL'(m_gnt != '0));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    m_gnt = '0;
    rst_n = 1'b0; per_req = '1; ch_en = '1; ch_cnt_nz = '1; ch_prio = '1; beat_done = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset gnt", NL'(gnt), '0);
    chk("R1 reset vld", NL'(gnt_vld), '0);
    rst_n = 1'b1;

    // R4: all eligible at same level -> channel 0
    step("R4 tie", '1, '1, '1, {NCH{2'b01}}, 1'b0);
    // R6: more urgent channel 4 appears, grant held
    step("R6 hold", '1, '1, '1, 10'b11_00_00_00_00, 1'b0);
    // R3/R7: beat completes with channel 4 very high
    step("R3 prio", '1, '1, '1, 10'b11_00_00_00_00, 1'b1);
    // R2: top channel disabled, then count zero
    step("R2 en", '1, 5'b01111, '1, 10'b11_10_00_10_00, 1'b1);
    step("R2 nz", '1, '1, 5'b10101, 10'b11_10_00_10_00, 1'b1);
    // R4: tie at high among 1 and 3
    step("R4 tie hi", '1, '1, 5'b01010, 10'b00_10_00_10_00, 1'b1);
    // R7: beat done, nobody eligible
    step("R7 empty", '0, '1, '1, '1, 1'b1);
    // R5: idle pickup without beat_done
    step("R5 pickup", 15'b000_000_010_000_000, '1, '1, '0, 1'b0);
    // R7: same owner re-wins
    step("R7 rewin", 15'b000_000_010_000_000, '1, '1, '0, 1'b1);

    for (int i = 0; i < 3000; i++) begin
      logic [NL-1:0] rq;
      rq = NL'($urandom) & NL'($urandom);
      step("R3 random", rq, NCH'($urandom) | NCH'($urandom), NCH'($urandom) | NCH'($urandom),
           (2*NCH)'($urandom), ($urandom % 3) == 0);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule